// File: doc/BRIEF.md
# Programmed I/O Command Sequencer

This block runs one software-built transfer at a time toward a bus-side engine. Software fills a small register file with an opcode, a target address, a pair of byte counts and up to sixteen 32-bit data words. It then sets a go bit. The sequencer checks the command and offers it to the engine through a valid/ready handshake. For a write it streams the buffered words out. For a read it collects the returned words back into the same data buffer. It then raises a done flag and, when enabled, an interrupt line.

The opcodes cover five cases: reading or writing the register space of the bus engine, reading a device, writing a device, and a combined device write followed by a read. A command that names an unknown opcode, a register-space address above 0xFF, or an empty or oversized transfer finishes at once with an error flag. Such a command causes no bus activity. While a transfer runs, only the status register may be written. Any other write is dropped and recorded as a sequence error.

Top module: `pio_seq_top`

## Requirements
- R1: After a synchronous reset, STATUS (word 1) reads 0, CTRL reads 0, irq is low, and cmd_valid and wr_valid are low.
- R2: Register words are CTRL=0 (bit0 go, bit1 interrupt enable), STATUS=1, OPCODE=2 (bits 7:0), ADDR=3 (bits 23:0), COUNT=4 (write bytes in bits 6:0, read bytes in bits 22:16), and data words 16..31. A reg_rdata value appears one cycle after reg_re. On an accepted go, cmd_valid rises carrying the opcode, the address and the byte counts, and holds stable until cmd_ready.
- R3: Write phase: data words 0..ceil(wr_bytes/4)-1 are offered in order on wr_data, each held until wr_ready.
- R4: Read phase: ceil(rd_bytes/4) words given on rd_valid/rd_data are stored into data words 0 upward. After a write-only command, the data words keep their values.
- R5: Opcode 0x1C performs the whole write phase before the read phase, and both counts are passed on.
- R6: Opcodes are 0x12 register read, 0x13 register write, 0x14 device read, 0x18 device write and 0x1C write-then-read. The count of an unused phase is passed as 0. Any other opcode, or opcode 0x12/0x13 with ADDR above 0xFF, sets STATUS bit4 and done with no handshake.
- R7: A used byte count of 0 or above 64 sets STATUS bit3 and done in the cycle after go, with no handshake. An invalid opcode reports bit4 only.
- R8: STATUS bit0 (busy) is high from an accepted go until the last word moves. At that point STATUS bit1 (done) sets.
- R9: While busy, a write to any register other than STATUS leaves it unchanged and sets STATUS bit2 (sequence error).
- R10: The go bit reads back as 0. STATUS bits 1 to 4 clear only when written with 1, bit by bit.
- R11: irq is high one cycle after done is set while the interrupt enable is 1. It stays low when the enable is 0 and falls after done is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_re |
| cmd_valid | output | 1 | Command offered to the bus engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr | output | 24 | Command target address |
| cmd_wr_bytes | output | 7 | Bytes to write (0 if no write phase) |
| cmd_rd_bytes | output | 7 | Bytes to read (0 if no read phase) |
| wr_valid | output | 1 | Write word offered |
| wr_ready | input | 1 | Engine takes the write word |
| wr_data | output | 32 | Write word |
| rd_valid | input | 1 | Read word returned by the engine |
| rd_data | input | 32 | Read word |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest state to reach from the ports is a register write that lands while a transfer is still running. The bench engine normally answers within a cycle or two, so the window is tiny. The engine model therefore has a hold switch. It stalls the command handshake, so the sequencer sits busy for as long as the bench needs. During that stall the bench writes ADDR and the go bit and reads both back. It then releases the engine and checks that done, the sequence error and the interrupt all show up together.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_OPC  = 2;
  localparam int A_ADDR = 3;
  localparam int A_CNT  = 4;
  localparam int RD_CNT_LSB = 16;
  localparam int REG_SPACE_MAX = 255;

  localparam logic [7:0] OP_REG_RD  = 8'h12;
  localparam logic [7:0] OP_REG_WR  = 8'h13;
  localparam logic [7:0] OP_DEV_RD  = 8'h14;
  localparam logic [7:0] OP_DEV_WR  = 8'h18;
  localparam logic [7:0] OP_DEV_WRD = 8'h1C;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_WFETCH, S_WSEND, S_READ} seq_state_t;

  typedef struct packed {
    logic valid;
    logic wr_phase;
    logic rd_phase;
    logic reg_space;
  } op_info_t;
endpackage

// File: rtl/pio_opdec.sv
module pio_opdec
  import pio_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 7,
  parameter int MAX_BYTES = 64
) (
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_bytes,
  input  logic [CNT_W-1:0]  rd_bytes,
  output op_info_t          info,
  output logic              bad_cmd,
  output logic              bad_len
);
  function automatic logic len_bad(input logic [CNT_W-1:0] b);
    return (b == '0) || (b > CNT_W'(MAX_BYTES));
  endfunction

  always_comb begin
    info = '0;
    case (opcode)
      OP_REG_RD:  info = '{valid: 1'b1, wr_phase: 1'b0, rd_phase: 1'b1, reg_space: 1'b1};
      OP_REG_WR:  info = '{valid: 1'b1, wr_phase: 1'b1, rd_phase: 1'b0, reg_space: 1'b1};
      OP_DEV_RD:  info = '{valid: 1'b1, wr_phase: 1'b0, rd_phase: 1'b1, reg_space: 1'b0};
      OP_DEV_WR:  info = '{valid: 1'b1, wr_phase: 1'b1, rd_phase: 1'b0, reg_space: 1'b0};
      OP_DEV_WRD: info = '{valid: 1'b1, wr_phase: 1'b1, rd_phase: 1'b1, reg_space: 1'b0};
      default:    info = '0;
    endcase
  end

  always_comb begin
    bad_cmd = !info.valid || (info.reg_space && (addr > ADDR_W'(REG_SPACE_MAX)));
    bad_len = !bad_cmd &&
              ((info.wr_phase && len_bad(wr_bytes)) || (info.rd_phase && len_bad(rd_bytes)));
  end
endmodule

// File: rtl/pio_buf.sv
module pio_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pio_fsm.sv
module pio_fsm
  import pio_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW  = $clog2(DEPTH),
  localparam int WCW = IW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [WCW-1:0] n_wr,
  input  logic [WCW-1:0] n_rd,
  input  logic           cmd_ready,
  input  logic           wr_ready,
  input  logic           rd_valid,
  output logic           busy,
  output logic           cmd_valid,
  output logic           wr_valid,
  output logic           fetching,
  output logic [IW-1:0]  fetch_idx,
  output logic           cap_we,
  output logic [IW-1:0]  cap_idx,
  output logic           finish
);
  seq_state_t     state;
  logic [IW-1:0]  widx, ridx;
  logic [WCW-1:0] nw_q, nr_q;
  logic           wlast, rlast;

  assign wlast = ({1'b0, widx} == nw_q - 1'b1);
  assign rlast = ({1'b0, ridx} == nr_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      widx  <= '0;
      ridx  <= '0;
      nw_q  <= '0;
      nr_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_CMD;
          widx  <= '0;
          ridx  <= '0;
          nw_q  <= n_wr;
          nr_q  <= n_rd;
        end
        S_CMD: if (cmd_ready) state <= (nw_q != '0) ? S_WFETCH : S_READ;
        S_WFETCH: state <= S_WSEND;
        S_WSEND: if (wr_ready) begin
          if (wlast) state <= (nr_q != '0) ? S_READ : S_IDLE;
          else begin
            widx  <= widx + 1'b1;
            state <= S_WFETCH;
          end
        end
        S_READ: if (rd_valid) begin
          if (rlast) state <= S_IDLE;
          else ridx <= ridx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != S_IDLE);
    cmd_valid = (state == S_CMD);
    wr_valid  = (state == S_WSEND);
    fetching  = (state == S_WFETCH) || (state == S_WSEND);
    fetch_idx = widx;
    cap_we    = (state == S_READ) && rd_valid;
    cap_idx   = ridx;
    finish    = ((state == S_WSEND) && wr_ready && wlast && (nr_q == '0)) ||
                ((state == S_READ) && rd_valid && rlast);
  end
endmodule

// File: rtl/pio_seq_top.sv
module pio_seq_top
  import pio_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = 24,
  localparam int IW        = $clog2(DEPTH),
  localparam int WCW       = IW + 1,
  localparam int MAX_BYTES = DEPTH * (DW / 8),
  localparam int CNT_W     = $clog2(MAX_BYTES) + 1,
  localparam int REG_AW    = IW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CNT_W-1:0]  cmd_wr_bytes,
  output logic [CNT_W-1:0]  cmd_rd_bytes,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DW-1:0]     wr_data,
  input  logic              rd_valid,
  input  logic [DW-1:0]     rd_data,
  output logic              irq
);
  logic [7:0]        opc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  wcnt_q, rcnt_q;
  logic irq_en_q, done_q, seqerr_q, badlen_q, badcmd_q, irq_q;
  logic rsel_mem_q;
  logic [DW-1:0] ctl_rd_q;

  op_info_t info;
  logic bad_cmd, bad_len;
  logic busy, fetching, cap_we, finish;
  logic [IW-1:0] fetch_idx, cap_idx;
  logic [WCW-1:0] n_wr, n_rd;
  logic [CNT_W:0] wsum, rsum;
  logic is_data, wr_ok, blocked, go, start, stat_we;
  logic [DW-1:0] buf_rdata;
  logic buf_we;
  logic [IW-1:0] buf_waddr, buf_raddr, reg_idx;
  logic [DW-1:0] buf_wdata;

  pio_opdec #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) dec_i (
    .opcode(opc_q), .addr(addr_q), .wr_bytes(wcnt_q), .rd_bytes(rcnt_q),
    .info(info), .bad_cmd(bad_cmd), .bad_len(bad_len)
  );

  assign wsum = {1'b0, wcnt_q} + (CNT_W+1)'(3);
  assign rsum = {1'b0, rcnt_q} + (CNT_W+1)'(3);
  assign n_wr = info.wr_phase ? WCW'(wsum >> 2) : '0;
  assign n_rd = info.rd_phase ? WCW'(rsum >> 2) : '0;

  assign is_data = reg_addr[REG_AW-1];
  assign reg_idx = reg_addr[IW-1:0];
  assign stat_we = reg_we && (reg_addr == REG_AW'(A_STAT));
  assign wr_ok   = reg_we && !busy;
  assign blocked = reg_we && busy && !stat_we;
  assign go      = wr_ok && (reg_addr == REG_AW'(A_CTRL)) && reg_wdata[0];
  assign start   = go && !bad_cmd && !bad_len;

  pio_fsm #(.DEPTH(DEPTH)) fsm_i (
    .clk(clk), .rst(rst), .start(start), .n_wr(n_wr), .n_rd(n_rd),
    .cmd_ready(cmd_ready), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .busy(busy), .cmd_valid(cmd_valid), .wr_valid(wr_valid),
    .fetching(fetching), .fetch_idx(fetch_idx),
    .cap_we(cap_we), .cap_idx(cap_idx), .finish(finish)
  );

  assign buf_we    = cap_we || (wr_ok && is_data);
  assign buf_waddr = cap_we ? cap_idx : reg_idx;
  assign buf_wdata = cap_we ? rd_data : reg_wdata;
  assign buf_raddr = fetching ? fetch_idx : reg_idx;

  pio_buf #(.DW(DW), .DEPTH(DEPTH)) buf_i (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  // Shadow registers for the command.
  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q    <= '0;
      addr_q   <= '0;
      wcnt_q   <= '0;
      rcnt_q   <= '0;
      irq_en_q <= 1'b0;
    end else if (wr_ok) begin
      case (int'(reg_addr))
        A_CTRL: irq_en_q <= reg_wdata[1];
        A_OPC:  opc_q    <= reg_wdata[7:0];
        A_ADDR: addr_q   <= reg_wdata[ADDR_W-1:0];
        A_CNT: begin
          wcnt_q <= reg_wdata[CNT_W-1:0];
          rcnt_q <= reg_wdata[RD_CNT_LSB +: CNT_W];
        end
        default: ;
      endcase
    end
  end

  // Sticky status: set wins over write-1-to-clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      seqerr_q <= 1'b0;
      badlen_q <= 1'b0;
      badcmd_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      done_q   <= (done_q   && !(stat_we && reg_wdata[1])) || finish || (go && (bad_cmd || bad_len));
      seqerr_q <= (seqerr_q && !(stat_we && reg_wdata[2])) || blocked;
      badlen_q <= (badlen_q && !(stat_we && reg_wdata[3])) || (go && bad_len);
      badcmd_q <= (badcmd_q && !(stat_we && reg_wdata[4])) || (go && bad_cmd);
      irq_q    <= irq_en_q && done_q;
    end
  end

  // Register read path, one cycle of latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_mem_q <= 1'b0;
      ctl_rd_q   <= '0;
    end else if (reg_re) begin
      rsel_mem_q <= is_data;
      case (int'(reg_addr))
        A_CTRL:  ctl_rd_q <= DW'({irq_en_q, 1'b0});
        A_STAT:  ctl_rd_q <= DW'({badcmd_q, badlen_q, seqerr_q, done_q, busy});
        A_OPC:   ctl_rd_q <= DW'(opc_q);
        A_ADDR:  ctl_rd_q <= DW'(addr_q);
        A_CNT:   ctl_rd_q <= DW'({rcnt_q, {(RD_CNT_LSB-CNT_W){1'b0}}, wcnt_q});
        default: ctl_rd_q <= '0;
      endcase
    end
  end

  assign reg_rdata    = rsel_mem_q ? buf_rdata : ctl_rd_q;
  assign cmd_opcode   = opc_q;
  assign cmd_addr     = addr_q;
  assign cmd_wr_bytes = info.wr_phase ? wcnt_q : '0;
  assign cmd_rd_bytes = info.rd_phase ? rcnt_q : '0;
  assign wr_data      = buf_rdata;
  assign irq          = irq_q;
endmodule

// File: rtl/pio_seq_chk.sv
module pio_seq_chk #(
  parameter int REG_AW = 5,
  parameter int DW     = 32,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              busy,
  input logic              seq_err,
  input logic              done,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_opcode,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DW-1:0]     wr_data,
  input logic              irq
);
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_opcode) && $stable(cmd_addr)); // R2
  AST_HS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_valid, wr_valid})); // R2
  AST_WR_HELD: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_valid && !wr_valid); // R8
  AST_BLOCK_FLAG: assert property (@(posedge clk) disable iff (rst)
    reg_we && busy && (reg_addr != REG_AW'(1)) |=> seq_err); // R9
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(done)); // R11
endmodule

bind pio_seq_top pio_seq_chk #(.REG_AW(REG_AW), .DW(DW), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .busy(busy),
  .seq_err(seqerr_q), .done(done_q), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_data(wr_data), .irq(irq)
);

// File: tb/pio_seq_top_tb_top.sv
module pio_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [6:0]  wb;
    logic [6:0]  rb;
    logic [1:0]  err;   // 0 ok, 1 bad length, 2 bad command
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{op: 8'h18, addr: 24'h123456, wb: 7'd8,  rb: 7'd0,  err: 2'd0},
    '{op: 8'h14, addr: 24'h000010, wb: 7'd0,  rb: 7'd12, err: 2'd0},
    '{op: 8'h1C, addr: 24'h00002A, wb: 7'd5,  rb: 7'd64, err: 2'd0},
    '{op: 8'h13, addr: 24'h0000FF, wb: 7'd64, rb: 7'd0,  err: 2'd0},
    '{op: 8'h12, addr: 24'h000100, wb: 7'd0,  rb: 7'd4,  err: 2'd2},
    '{op: 8'h18, addr: 24'h000020, wb: 7'd0,  rb: 7'd9,  err: 2'd1},
    '{op: 8'h14, addr: 24'h000020, wb: 7'd3,  rb: 7'd65, err: 2'd1},
    '{op: 8'h55, addr: 24'h000000, wb: 7'd0,  rb: 7'd0,  err: 2'd2},
    '{op: 8'h12, addr: 24'h000080, wb: 7'd0,  rb: 7'd1,  err: 2'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cmd_valid, cmd_ready, wr_valid, wr_ready, rd_valid, irq;
  logic [7:0] cmd_opcode;
  logic [23:0] cmd_addr;
  logic [6:0] cmd_wr_bytes, cmd_rd_bytes;
  logic [31:0] wr_data, rd_data;

  int n_checks = 0, n_fail = 0;
  logic hold = 1'b0;
  int e_tag = 0;
  int ncmd = 0, nwr = 0;
  logic [7:0] e_op;
  logic [23:0] e_addr;
  logic [6:0] e_wb, e_rb;
  logic [31:0] wcap [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_seq_top dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_wr_bytes(cmd_wr_bytes), .cmd_rd_bytes(cmd_rd_bytes), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq(irq)
  );

  function automatic logic [31:0] wpat(int v, int i);
    return 32'h5A00_0000 + 32'(v << 8) + 32'(i);
  endfunction
  function automatic logic [31:0] rpat(int v, int i);
    return 32'hC0DE_0000 ^ 32'((v << 8) + i);
  endfunction

  // Bus engine model.
  initial begin
    cmd_ready = 1'b0; wr_ready = 1'b1; rd_valid = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      if (cmd_valid && !hold) begin
        e_op = cmd_opcode; e_addr = cmd_addr; e_wb = cmd_wr_bytes; e_rb = cmd_rd_bytes;
        ncmd++;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        nwr = 0;
        while (nwr < (int'(e_wb) + 3) / 4) begin
          if (wr_valid) begin wcap[nwr] = wr_data; nwr++; end
          @(negedge clk);
        end
        for (int i = 0; i < (int'(e_rb) + 3) / 4; i++) begin
          rd_valid = 1'b1; rd_data = rpat(e_tag, i);
          @(negedge clk);
          rd_valid = 1'b0;
          @(negedge clk);
        end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_re = 1'b1; reg_addr = AW'(a);
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = '0;
    for (int k = 0; k < 400; k++) begin
      rd(1, st);
      if (st[1]) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    report();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] st;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(1, v); chk(v == 0, "R1 status", v, 0);
    rd(0, v); chk(v == 0, "R1 ctrl", v, 0);
    chk(!irq && !cmd_valid && !wr_valid, "R1 outputs", {irq, cmd_valid, wr_valid}, 0);

    // Vector table
    for (int t = 0; t < NV; t++) begin
      int nb, nw, nr, exp_wb, exp_rb;
      logic wph, rph;
      logic [31:0] exp_st;
      nb = ncmd;
      e_tag = t;
      wph = (VECS[t].op == 8'h13) || (VECS[t].op == 8'h18) || (VECS[t].op == 8'h1C);
      rph = (VECS[t].op == 8'h12) || (VECS[t].op == 8'h14) || (VECS[t].op == 8'h1C);
      exp_wb = wph ? int'(VECS[t].wb) : 0;
      exp_rb = rph ? int'(VECS[t].rb) : 0;
      nw = (exp_wb + 3) / 4;
      nr = (exp_rb + 3) / 4;
      for (int i = 0; i < 16; i++) wr(16 + i, wpat(t, i));
      wr(2, 32'(VECS[t].op));
      wr(3, 32'(VECS[t].addr));
      wr(4, (32'(VECS[t].rb) << 16) | 32'(VECS[t].wb));
      wr(0, 32'h1);
      wait_done(st);
      exp_st = 32'h2 | ((VECS[t].err == 2'd1) ? 32'h8 : 0) | ((VECS[t].err == 2'd2) ? 32'h10 : 0);
      chk(st == exp_st, (VECS[t].err == 2'd0) ? "R8 done status" :
                        (VECS[t].err == 2'd1) ? "R7 bad length status" : "R6 bad command status",
          st, exp_st);
      if (VECS[t].err != 2'd0) begin
        chk(ncmd == nb, "R6 R7 no handshake on error", 32'(ncmd), 32'(nb));
      end else begin
        chk(ncmd == nb + 1, "R2 one command", 32'(ncmd), 32'(nb + 1));
        chk(e_op == VECS[t].op && e_addr == VECS[t].addr, "R2 command fields",
            {e_op, e_addr}, {VECS[t].op, VECS[t].addr});
        chk(int'(e_wb) == exp_wb && int'(e_rb) == exp_rb, "R6 phase counts",
            {e_wb, 9'd0, e_rb}, 32'((exp_wb << 16) | exp_rb));
        chk(nwr == nw, "R3 write word count", 32'(nwr), 32'(nw));
        for (int i = 0; i < nw; i++)
          chk(wcap[i] == wpat(t, i), (VECS[t].op == 8'h1C) ? "R5 write before read data" : "R3 write data",
              wcap[i], wpat(t, i));
        for (int i = 0; i < nr; i++) begin
          rd(16 + i, v);
          chk(v == rpat(t, i), (VECS[t].op == 8'h1C) ? "R5 read after write data" : "R4 read data",
              v, rpat(t, i));
        end
        if (!rph) begin
          rd(16, v);
          chk(v == wpat(t, 0), "R4 write-only keeps buffer", v, wpat(t, 0));
        end
      end
      wr(1, 32'h1E);
    end

    // R7: error completes in the cycle after go
    wr(2, 32'h14); wr(4, 32'h0);
    wr(0, 32'h1);
    rd(1, v);
    chk(v == 32'h0A, "R7 immediate done with bad length", v, 32'h0A);
    @(negedge clk);
    chk(!irq, "R11 irq low when disabled", irq, 0);
    wr(1, 32'h1E);

    // R9/R10/R11: blocked writes while the engine stalls
    hold = 1'b1;
    e_tag = 20;
    wr(2, 32'h14); wr(3, 32'h77); wr(4, 32'h8 << 16);
    wr(0, 32'h3);
    rd(1, v);
    chk(v == 32'h1, "R8 busy during transfer", v, 32'h1);
    wr(3, 32'h999);
    wr(0, 32'h1);
    rd(3, v);
    chk(v == 32'h77, "R9 blocked address write", v, 32'h77);
    rd(1, v);
    chk(v == 32'h5, "R9 sequence error set", v, 32'h5);
    hold = 1'b0;
    wait_done(st);
    chk(st == 32'h6, "R8 done with sequence error", st, 32'h6);
    chk(ncmd == NV - 4 + 1 + 0 + 1 - 1 + 1 - 1, "R9 blocked go started nothing", 32'(ncmd), 32'(NV - 4 + 1));
    rd(0, v);
    chk(v == 32'h2, "R10 go reads back zero", v, 32'h2);
    @(negedge clk);
    chk(irq, "R11 irq raised", irq, 1);
    wr(1, 32'h4);
    rd(1, v);
    chk(v == 32'h2, "R10 clear only sequence error", v, 32'h2);
    wr(1, 32'h2);
    rd(1, v);
    chk(v == 32'h0, "R10 done cleared", v, 0);
    @(negedge clk);
    chk(!irq, "R11 irq falls after clear", irq, 0);
    report();
  end
endmodule